// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down-counters behind a four-address byte-wide register port. Addresses 0, 1 and 2 reach the counters of channels 0, 1 and 2; address 3 takes a control word that configures one channel or freezes a snapshot of its count. Every counter steps only on cycles where the enable input `tick_en` is high. That enable is derived outside the block from a nominal 1.193182 MHz reference.

Channel 0's output is the periodic system tick request. Channel 1 runs freely for general use. Channel 2 is gated by an external control bit that also enables the speaker, so the speaker line carries channel 2's square wave only while that bit is set. Each channel runs either as a rate generator, which gives one low enable period per cycle, or as a square-wave generator. A divisor of zero means a full 65536-count period. Software may rewrite a divisor at any time without resetting the block.

Top module: `tick_timer3`

## Requirements
- R1: After reset every channel is idle. `irq_tick`, `out_ch1` and `out_ch2` are high, `spk_out` is low while `spk_gate` is low, and reading a counter address returns 0x00.
- R2: A write to address 3 is a control word. Bits 7:6 select the channel (0, 1 or 2); the value 3 is ignored. Bits 5:4 select the access: 00 latches the count, 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. Bit 1 selects the mode: 0 is rate generator, 1 is square wave. Bits 3, 2 and 0 are ignored.
- R3: With low-only access, one byte written gives a divisor whose high byte is zero, and a read returns the low byte of the count. With high-only access, the written byte is the high byte with a zero low byte, and a read returns the high byte of the count.
- R4: A control word that is not a latch command does three things to its channel: it stops the channel with its output held high until a complete divisor is written, and it resets both the write and the read byte pointers to the low byte.
- R5: In rate-generator mode with divisor N, the output repeats every N enable pulses and is low for exactly one of them.
- R6: In square-wave mode with divisor N, the output is high for ceil(N/2) enable pulses and low for floor(N/2) pulses in each period.
- R7: A divisor of 0 gives a 65536-pulse period in both modes, which is about 18.2 Hz from a 1.193182 MHz enable. Loading 0 leaves the count at 0, and the next pulse takes it to 0xFFFF.
- R8: A divisor written without a preceding control word leaves the current period unchanged and takes effect from the next reload.
- R9: A latch command copies the count. Reads return that copy until all bytes for the access mode have been read. A further latch command is ignored while a copy is held.
- R10: Without a latch, a read returns the live count.
- R11: While `spk_gate` is low, channel 2 does not count, `out_ch2` is high and `spk_out` is low. When the gate rises, the counter reloads its full divisor on the next enable pulse. While the gate is high, `spk_out` follows `out_ch2`.
- R12: After a control word, a completed divisor is loaded on the first enable pulse that follows its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable pulse |
| bus_addr | input | 2 | Register address: 0 to 2 counters, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the read byte pointer) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally for the addressed register |
| spk_gate | input | 1 | Channel 2 gate and speaker enable |
| irq_tick | output | 1 | Channel 0 output, periodic tick request |
| out_ch1 | output | 1 | Channel 1 output |
| out_ch2 | output | 1 | Channel 2 output |
| spk_out | output | 1 | Speaker drive: channel 2 output qualified by the gate |

## Verification
A bus write takes effect at the clock edge that samples it. A count reaches its counter on the first enabled edge after that, and the channel outputs are decoded combinationally from the counter, so each result can be seen at the falling edge that follows the responsible rising edge. The bench changes inputs and samples outputs only on falling edges. Every sample therefore counts exactly one enable pulse, and waveform lengths are measured in pulses, not absolute times. Read data is combinational from the address and state, so the bench samples it one time unit after setting the address, before the edge that moves the byte pointer.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  typedef enum logic {
    MD_RATE   = 1'b0,
    MD_SQUARE = 1'b1
  } mode_e;

  // A stored zero stands for the full 2**CNT_W span.
  function automatic logic [CNT_W:0] span(input logic [CNT_W-1:0] v);
    return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
  endfunction

  // Square wave: high while the remaining count exceeds half the period.
  function automatic logic sq_level(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] div);
    return span(cnt) > (span(div) >> 1);
  endfunction

  // Rate generator: low only on the terminal count.
  function automatic logic rate_level(input logic [CNT_W-1:0] cnt);
    return cnt != CNT_W'(1);
  endfunction
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
  import pit_pkg::*;
#(
  parameter int CH = NUM_CH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [CH-1:0]    ctl_wr,
  output logic [CH-1:0]    latch_cmd,
  output logic [CH-1:0]    data_wr,
  output logic [CH-1:0]    rd_stb,
  output acc_e             cfg_acc,
  output mode_e            cfg_mode
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic ctl_access;
  logic [1:0] sel;
  logic unused_cfg_bits;

  assign ctl_access      = bus_wr && (bus_addr == CTRL_ADDR);
  assign sel             = bus_wdata[7:6];
  assign cfg_acc         = acc_e'(bus_wdata[5:4]);
  assign cfg_mode        = mode_e'(bus_wdata[1]);
  assign unused_cfg_bits = ^{bus_wdata[3:2], bus_wdata[0]};

  for (genvar i = 0; i < CH; i++) begin : g_dec
    assign ctl_wr[i]    = ctl_access && (sel == 2'(i)) && (cfg_acc != ACC_LATCH);
    assign latch_cmd[i] = ctl_access && (sel == 2'(i)) && (cfg_acc == ACC_LATCH);
    assign data_wr[i]   = bus_wr && (bus_addr == 2'(i));
    assign rd_stb[i]    = bus_rd && (bus_addr == 2'(i));
  end

  // R2: one bus cycle touches at most one channel
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_wr | latch_cmd | data_wr));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       gate,
  input  logic       ctl_wr,
  input  acc_e       cfg_acc,
  input  mode_e      cfg_mode,
  input  logic       latch_cmd,
  input  logic       data_wr,
  input  logic       rd_stb,
  input  logic [7:0] wdata,
  output logic       out,
  output logic [7:0] rd_byte
);
  acc_e         acc;
  mode_e        mode;
  logic         running, load_pend, wr_ff, rd_ff, latched;
  logic [W-1:0] count, div_active, div_new, latch_val;
  logic [7:0]   lo_hold;

  logic         tick_ok, at_term, hi_sel;
  logic [W-1:0] rd_src;

  assign tick_ok = tick_en && gate;
  assign at_term = (count == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= ACC_LOHI;
      mode       <= MD_RATE;
      running    <= 1'b0;
      load_pend  <= 1'b0;
      wr_ff      <= 1'b0;
      rd_ff      <= 1'b0;
      latched    <= 1'b0;
      count      <= '0;
      div_active <= '0;
      div_new    <= '0;
      latch_val  <= '0;
      lo_hold    <= '0;
    end else begin
      // counting
      if (!gate) begin
        if (running) begin
          running   <= 1'b0;
          load_pend <= 1'b1;
        end
      end else if (tick_en) begin
        if (!running) begin
          if (load_pend) begin
            count      <= div_new;
            div_active <= div_new;
            running    <= 1'b1;
            load_pend  <= 1'b0;
          end
        end else if (at_term) begin
          count      <= load_pend ? div_new : div_active;
          div_active <= load_pend ? div_new : div_active;
          load_pend  <= 1'b0;
        end else begin
          count <= count - W'(1);
        end
      end

      // configuration and divisor writes
      if (ctl_wr) begin
        acc       <= cfg_acc;
        mode      <= cfg_mode;
        running   <= 1'b0;
        load_pend <= 1'b0;
        wr_ff     <= 1'b0;
        rd_ff     <= 1'b0;
        latched   <= 1'b0;
      end else if (data_wr) begin
        unique case (acc)
          ACC_LO: begin
            div_new   <= {{(W-8){1'b0}}, wdata};
            load_pend <= 1'b1;
          end
          ACC_HI: begin
            div_new   <= {wdata, {(W-8){1'b0}}};
            load_pend <= 1'b1;
          end
          default: begin
            if (!wr_ff) begin
              lo_hold <= wdata;
              wr_ff   <= 1'b1;
            end else begin
              div_new   <= {wdata, lo_hold};
              wr_ff     <= 1'b0;
              load_pend <= 1'b1;
            end
          end
        endcase
      end

      // snapshot
      if (latch_cmd && !latched) begin
        latched   <= 1'b1;
        latch_val <= count;
      end

      // read pointer
      if (rd_stb) begin
        if (acc == ACC_LOHI) begin
          if (!rd_ff) rd_ff <= 1'b1;
          else begin
            rd_ff   <= 1'b0;
            latched <= 1'b0;
          end
        end else begin
          latched <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (!(running && gate)) out = 1'b1;
    else if (mode == MD_SQUARE) out = sq_level(count, div_active);
    else out = rate_level(count);
  end

  assign rd_src  = latched ? latch_val : count;
  assign hi_sel  = (acc == ACC_HI) || ((acc == ACC_LOHI) && rd_ff);
  assign rd_byte = hi_sel ? rd_src[W-1 -: 8] : rd_src[7:0];

  // R5 / R7: a running counter steps down by one per pulse, wrapping 0 to all-ones
  assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && $past(tick_ok) && $past(count) != W'(1))
      |-> count == W'($past(count) - W'(1)));

  // R8: a reload at terminal count lands on the divisor now in force
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running && tick_ok && at_term && !ctl_wr) |-> count == div_active);

  // R9: a held snapshot never changes
  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && $past(latched)) |-> $stable(latch_val));

  // R4: a control word idles the channel and clears the write pointer
  assert_ctrl_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr) |-> (!running && !wr_ff && !rd_ff));

  // R11: with the gate held low the count is frozen
  assert_gate_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && $past(!gate)) |=> $stable(count));
endmodule

// File: rtl/tick_timer3.sv
module tick_timer3
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       spk_gate,
  output logic       irq_tick,
  output logic       out_ch1,
  output logic       out_ch2,
  output logic       spk_out
);
  localparam int SPK_CH = NUM_CH - 1;

  logic [NUM_CH-1:0] ctl_wr, latch_cmd, data_wr, rd_stb, ch_out, ch_gate;
  logic [7:0]        ch_rd [NUM_CH];
  acc_e              cfg_acc;
  mode_e             cfg_mode;

  pit_bus_decode #(.CH(NUM_CH)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctl_wr    (ctl_wr),
    .latch_cmd (latch_cmd),
    .data_wr   (data_wr),
    .rd_stb    (rd_stb),
    .cfg_acc   (cfg_acc),
    .cfg_mode  (cfg_mode)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == SPK_CH) begin : g_gated
      assign ch_gate[i] = spk_gate;
    end else begin : g_free
      assign ch_gate[i] = 1'b1;
    end

    pit_channel #(.W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .gate      (ch_gate[i]),
      .ctl_wr    (ctl_wr[i]),
      .cfg_acc   (cfg_acc),
      .cfg_mode  (cfg_mode),
      .latch_cmd (latch_cmd[i]),
      .data_wr   (data_wr[i]),
      .rd_stb    (rd_stb[i]),
      .wdata     (bus_wdata),
      .out       (ch_out[i]),
      .rd_byte   (ch_rd[i])
    );
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_addr == 2'(i)) bus_rdata = ch_rd[i];
  end

  assign irq_tick = ch_out[0];
  assign out_ch1  = ch_out[1];
  assign out_ch2  = ch_out[SPK_CH];
  assign spk_out  = ch_out[SPK_CH] && spk_gate;

  // R11: the speaker is silent whenever its gate is low
  assert_spk_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !spk_gate |-> !spk_out);
endmodule

// File: tb/tick_timer3_test.sv
module tick_timer3_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spk_gate = 1'b0;
  logic       irq_tick, out_ch1, out_ch2, spk_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer3 uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spk_gate(spk_gate), .irq_tick(irq_tick), .out_ch1(out_ch1),
    .out_ch2(out_ch2), .spk_out(spk_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  function automatic logic pick(input int ch);
    return (ch == 0) ? irq_tick : (ch == 1) ? out_ch1 : out_ch2;
  endfunction

  // one full period after the next falling edge of the chosen output
  task automatic measure(input int ch, output int lows, output int highs);
    int g = 0;
    lows = 0; highs = 0;
    while (pick(ch) == 1'b0 && g < 70000) begin @(negedge clk); g++; end
    while (pick(ch) == 1'b1 && g < 70000) begin @(negedge clk); g++; end
    while (pick(ch) == 1'b0 && g < 140000) begin lows++; @(negedge clk); g++; end
    while (pick(ch) == 1'b1 && g < 140000) begin highs++; @(negedge clk); g++; end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_tick", irq_tick, 1);
    chk("R1 out_ch1", out_ch1, 1);
    chk("R1 out_ch2", out_ch2, 1);
    chk("R1 spk_out", spk_out, 0);
    rd(2'd0, d);
    chk("R1 read count", d, 0);
  endtask

  task automatic t_rate();
    int lo, hi;
    wr(2'd3, 8'h34); wr(2'd0, 8'd5); wr(2'd0, 8'd0);
    @(negedge clk); tick_en = 1'b1;
    measure(0, lo, hi);
    chk("R5 rate low pulses", lo, 1);
    chk("R5 rate high pulses", hi, 4);
    tick_en = 1'b0;
  endtask

  task automatic t_square();
    int lo, hi;
    wr(2'd3, 8'h76); wr(2'd1, 8'd5); wr(2'd1, 8'd0);
    @(negedge clk); tick_en = 1'b1;
    measure(1, lo, hi);
    chk("R6 odd low", lo, 2);
    chk("R6 odd high", hi, 3);
    tick_en = 1'b0;
    wr(2'd3, 8'h76); wr(2'd1, 8'd4); wr(2'd1, 8'd0);
    @(negedge clk); tick_en = 1'b1;
    measure(1, lo, hi);
    chk("R6 even low", lo, 2);
    chk("R6 even high", hi, 2);
    tick_en = 1'b0;
  endtask

  task automatic t_reprogram();
    int lo, hi;
    wr(2'd3, 8'h34); wr(2'd0, 8'd6); wr(2'd0, 8'd0);
    @(negedge clk); tick_en = 1'b1;
    measure(0, lo, hi);
    chk("R8 first period high", hi, 5);
    wr(2'd0, 8'd3); wr(2'd0, 8'd0);
    measure(0, lo, hi);
    chk("R8 new period low", lo, 1);
    chk("R8 new period high", hi, 2);
  endtask

  task automatic t_ctrl_stop();
    int lows = 0;
    wr(2'd3, 8'h34);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!irq_tick) lows++;
    end
    chk("R4 idle after control word", lows, 0);
    tick_en = 1'b0;
  endtask

  task automatic t_latch();
    logic [7:0] l, h;
    wr(2'd3, 8'h34); wr(2'd0, 8'h00); wr(2'd0, 8'h10);
    pulse(1);
    chk("R12 loaded count", irq_tick, 1);
    pulse(10);
    wr(2'd3, 8'h00);
    pulse(5);
    wr(2'd3, 8'h00);
    pulse(5);
    rd(2'd0, l); rd(2'd0, h);
    chk("R9 latched value", {h, l}, 16'h0FF6);
    rd(2'd0, l); rd(2'd0, h);
    chk("R10 live value", {h, l}, 16'h0FEC);
  endtask

  task automatic t_access();
    logic [7:0] d;
    wr(2'd3, 8'h54); wr(2'd1, 8'h07);
    pulse(1);
    rd(2'd1, d);
    chk("R3 low-only", d, 8'h07);
    wr(2'd3, 8'h64); wr(2'd1, 8'h01);
    pulse(1);
    rd(2'd1, d);
    chk("R3 high-only at 0x0100", d, 8'h01);
    pulse(1);
    rd(2'd1, d);
    chk("R3 high-only at 0x00FF", d, 8'h00);
  endtask

  task automatic t_byte_order();
    logic [7:0] l, h;
    wr(2'd3, 8'h74); wr(2'd1, 8'h22);
    wr(2'd3, 8'h74); wr(2'd1, 8'h08); wr(2'd1, 8'h00);
    pulse(1);
    wr(2'd3, 8'h40);
    rd(2'd1, l);
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h08); wr(2'd1, 8'h00);
    pulse(1);
    rd(2'd1, l); rd(2'd1, h);
    chk("R4 pointer reset", {h, l}, 16'h0008);
  endtask

  task automatic t_gate();
    int lo, hi, bad = 0;
    logic [7:0] l, h;
    spk_gate = 1'b0;
    wr(2'd3, 8'hB6); wr(2'd2, 8'd4); wr(2'd2, 8'd0);
    @(negedge clk); tick_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!out_ch2 || spk_out) bad++;
    end
    chk("R11 gate low output", bad, 0);
    tick_en = 1'b0;
    rd(2'd2, l); rd(2'd2, h);
    chk("R11 no count while gated", {h, l}, 0);
    spk_gate = 1'b1;
    @(negedge clk); tick_en = 1'b1;
    measure(2, lo, hi);
    chk("R11 square low", lo, 2);
    chk("R11 square high", hi, 2);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (spk_out != out_ch2) bad++;
    end
    chk("R11 speaker follows", bad, 0);
    spk_gate = 1'b0;
    #1 chk("R11 gate drop output", out_ch2, 1);
    chk("R11 gate drop speaker", spk_out, 0);
    @(negedge clk); tick_en = 1'b0;
    spk_gate = 1'b1;
    pulse(1);
    wr(2'd3, 8'h80);
    rd(2'd2, l); rd(2'd2, h);
    chk("R11 reload on gate rise", {h, l}, 4);
  endtask

  task automatic t_zero();
    logic [7:0] l, h;
    int hi = 0, lo = 0;
    wr(2'd3, 8'h34); wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    pulse(1);
    rd(2'd0, l); rd(2'd0, h);
    chk("R7 zero loaded", {h, l}, 0);
    pulse(1);
    rd(2'd0, l); rd(2'd0, h);
    chk("R7 wraps to all ones", {h, l}, 16'hFFFF);
    wr(2'd3, 8'h34); wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    @(negedge clk); tick_en = 1'b1;
    for (int g = 0; g < 70000; g++) begin
      @(negedge clk);
      if (irq_tick) hi++;
      else break;
    end
    while (!irq_tick && lo < 10) begin lo++; @(negedge clk); end
    chk("R7 full period high", hi, 65535);
    chk("R7 full period low", lo, 1);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_square();
    t_reprogram();
    t_ctrl_stop();
    t_latch();
    t_access();
    t_byte_order();
    t_gate();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule